// File: doc/BRIEF.md
# Armed Reconfiguration Trigger

This block is a control register with a two-step arming scheme that protects a device against accidental reboots. Software first writes the unlock bit, which arms the block. A later, separate write that sets the trigger bit, with the unlock bit clear, starts a sequencer. The sequencer streams a fixed series of 16-bit reconfiguration command words toward an internal configuration access port. Any write that leaves the unlock bit clear disarms the block. A trigger that is not armed, or that arrives in the same write as the unlock bit, therefore does nothing.

The command stream is a dummy word, two synchronisation words, a command-register write header, the reboot opcode and a parameterised number of no-op words. Words go out in that order. The sequencer holds each word on the port while the port reports busy and moves on by one word per cycle whenever the port accepts. The same register also carries a boot-status request bit, which raises a one-cycle request pulse. The register reads back an armed flag and a running flag.

Top module: `reboot_trigger`

## Requirements
- R1: After reset, cfg_valid, status_req and cfg_word are 0, and the control register reads back as 0.
- R2: A control-register write with bit 16 (unlock) = 1 and bit 17 (trigger) = 0 arms the block. Bit 16 of the readback is then 1.
- R3: When the block is armed and idle, a control write with bit 17 = 1 and bit 16 = 0 raises cfg_valid in the cycle after the write, with cfg_word = 0xFFFF.
- R4: A trigger write made while the block is not armed starts nothing: cfg_valid stays 0.
- R5: A write that sets bits 16 and 17 together does not start the sequence. It only arms the block.
- R6: Any control write with bit 16 = 0 disarms the block, so a following trigger write is ignored.
- R7: The stream is 0xFFFF, 0xAA99, 0x5566, 0x30A1, 0x000E, followed by NOOP_WORDS copies of 0x2000. It has exactly 5 + NOOP_WORDS accepted words, and then cfg_valid falls.
- R8: While cfg_busy is 1, cfg_valid stays 1 and cfg_word holds its value. One word is accepted at each clock edge where cfg_valid = 1 and cfg_busy = 0.
- R9: While the sequence runs, readback bit 18 (running) is 1. Starting the sequence clears the armed bit. Trigger writes during the run neither restart nor lengthen the stream.
- R10: A control write with bit 0 = 1 raises status_req for exactly the one cycle after the write. Readback bit 0 is always 0.
- R11: Writes to any address other than CTRL_ADDR change neither the armed state nor the outputs.
- R12: Readback bits 15..1 and bits 31..19 are 0 whatever was written to them. The readback at any other address is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 32 | Combinational readback |
| cfg_word | output | 16 | Command word toward the configuration port |
| cfg_valid | output | 1 | cfg_word is valid |
| cfg_busy | input | 1 | Port cannot accept this cycle |
| status_req | output | 1 | One-cycle boot-status request |

## Verification
A wrong armed flag shows up one cycle after the trigger write: cfg_valid either rises when it must not or stays low when it must rise. The bench also reads the armed flag back on rd_data right after every write. A sequencer index that skips, repeats or stops early shows on cfg_word at the next accepted word, or as a wrong word count when cfg_valid falls. The bench sweeps every combination of prior arming and the two bits in the trigger write, and drains the stream under several stall patterns.

// File: rtl/rbt_pkg.sv
package rbt_pkg;
    localparam int DATA_W   = 32;
    localparam int WORD_W   = 16;
    localparam int TRIG_BIT = 17;
    localparam int UNL_BIT  = 16;
    localparam int STAT_BIT = 0;
    localparam int RUN_BIT  = 18;
    localparam int HEAD_WORDS = 5;

    localparam logic [WORD_W-1:0] W_DUMMY = 16'hFFFF;
    localparam logic [WORD_W-1:0] W_SYNC0 = 16'hAA99;
    localparam logic [WORD_W-1:0] W_SYNC1 = 16'h5566;
    localparam logic [WORD_W-1:0] W_CMDWR = 16'h30A1;
    localparam logic [WORD_W-1:0] W_REBOOT = 16'h000E;
    localparam logic [WORD_W-1:0] W_NOOP  = 16'h2000;

    typedef struct packed {
        logic armed;
        logic stat;
    } ctrl_state_t;

    function automatic logic [WORD_W-1:0] seq_word(input int unsigned idx);
        case (idx)
            0: return W_DUMMY;
            1: return W_SYNC0;
            2: return W_SYNC1;
            3: return W_CMDWR;
            4: return W_REBOOT;
            default: return W_NOOP;
        endcase
    endfunction
endpackage

// File: rtl/rbt_ctrl_regs.sv
module rbt_ctrl_regs
    import rbt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic              wr_unl,
    input  logic              wr_trig,
    input  logic              wr_stat,
    input  logic              seq_running,
    output logic              start_o,
    output logic              armed_o,
    output logic              stat_req_o
);
    ctrl_state_t st_d, st_q;
    logic        hit;

    always_comb begin
        st_d    = st_q;
        st_d.stat = 1'b0;
        start_o = 1'b0;
        hit     = wr_en && (wr_addr == CTRL_ADDR);
        if (hit) begin
            // every write to the register re-evaluates arming
            st_d.armed = wr_unl;
            st_d.stat  = wr_stat;
            if (wr_trig && !wr_unl && st_q.armed && !seq_running) begin
                start_o = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign armed_o    = st_q.armed;
    assign stat_req_o = st_q.stat;

    assert_disarm_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !armed_o);
    assert_unlock_arms_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && wr_unl) |=> armed_o);
    assert_clear_disarms_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !wr_unl) |=> !armed_o);
    assert_other_addr_keeps_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr != CTRL_ADDR) |=> $stable(armed_o));
endmodule

// File: rtl/rbt_cmd_seq.sv
module rbt_cmd_seq
    import rbt_pkg::*;
#(
    parameter int NOOP_WORDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              port_busy_i,
    output logic [WORD_W-1:0] word_o,
    output logic              valid_o,
    output logic              running_o
);
    localparam int SEQ_LEN = HEAD_WORDS + NOOP_WORDS;
    localparam int IDX_W   = $clog2(SEQ_LEN);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(SEQ_LEN - 1);

    typedef struct packed {
        logic             run;
        logic [IDX_W-1:0] idx;
    } seq_state_t;

    seq_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!st_q.run) begin
            if (start_i) begin
                st_d.run = 1'b1;
                st_d.idx = '0;
            end
        end else if (!port_busy_i) begin
            if (st_q.idx == LAST_IDX) begin
                st_d.run = 1'b0;
                st_d.idx = '0;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid_o   = st_q.run;
    assign running_o = st_q.run;
    assign word_o    = st_q.run ? seq_word(32'(st_q.idx)) : '0;

    assert_hold_on_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && port_busy_i) |=> (valid_o && $stable(word_o)));
    assert_idx_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.run |-> (st_q.idx <= LAST_IDX));
    assert_no_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && port_busy_i && start_i) |=> $stable(st_q.idx));
endmodule

// File: rtl/rbt_readback.sv
module rbt_readback
    import rbt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic              armed_i,
    input  logic              running_i,
    output logic [DATA_W-1:0] rd_data
);
    always_comb begin
        rd_data = '0;
        if (rd_addr == CTRL_ADDR) begin
            rd_data[UNL_BIT] = armed_i;
            rd_data[RUN_BIT] = running_i;
        end
    end
endmodule

// File: rtl/reboot_trigger.sv
module reboot_trigger
    import rbt_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
    parameter int NOOP_WORDS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    output logic [15:0]       cfg_word,
    output logic              cfg_valid,
    input  logic              cfg_busy,
    output logic              status_req
);
    logic start, armed, running;
    logic unused_wr_bits;

    assign unused_wr_bits = ^{wr_data[31:18], wr_data[15:1]};

    rbt_ctrl_regs #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_unl(wr_data[UNL_BIT]), .wr_trig(wr_data[TRIG_BIT]),
        .wr_stat(wr_data[STAT_BIT]), .seq_running(running),
        .start_o(start), .armed_o(armed), .stat_req_o(status_req)
    );

    rbt_cmd_seq #(.NOOP_WORDS(NOOP_WORDS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start), .port_busy_i(cfg_busy),
        .word_o(cfg_word), .valid_o(cfg_valid), .running_o(running)
    );

    rbt_readback #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)) u_rb (
        .rd_addr(rd_addr), .armed_i(armed), .running_i(running), .rd_data(rd_data)
    );

    assert_start_needs_arm_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid) |-> $past(armed));
    assert_first_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid) |-> (cfg_word == W_DUMMY));
    assert_no_combined_fire_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_valid) |-> $past(wr_en && wr_addr == CTRL_ADDR
                                   && wr_data[TRIG_BIT] && !wr_data[UNL_BIT]));
    assert_status_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        status_req |-> $past(wr_en && wr_addr == CTRL_ADDR && wr_data[STAT_BIT]));
endmodule

// File: tb/sim_reboot_trigger.sv
module sim_reboot_trigger;
    localparam int NOOPS = 2;
    localparam int LEN   = 5 + NOOPS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [3:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [15:0] cfg_word;
    logic        cfg_valid;
    logic        cfg_busy = 1'b0;
    logic        status_req;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    reboot_trigger #(.ADDR_W(4), .CTRL_ADDR(4'h0), .NOOP_WORDS(NOOPS)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .cfg_word(cfg_word), .cfg_valid(cfg_valid), .cfg_busy(cfg_busy),
        .status_req(status_req)
    );

    function automatic logic [15:0] exp_word(input int i);
        if (i == 0) return 16'hFFFF;
        if (i == 1) return 16'hAA99;
        if (i == 2) return 16'h5566;
        if (i == 3) return 16'h30A1;
        if (i == 4) return 16'h000E;
        return 16'h2000;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic read_reg(input logic [3:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    // stall pattern: 0 none, 1 every other cycle, 2 two of three
    function automatic bit stall(input int mode, input int k);
        if (mode == 1) return (k % 2) == 1;
        if (mode == 2) return (k % 3) != 0;
        return 1'b0;
    endfunction

    // called at a negedge with cfg_valid expected high
    task automatic drain(input int mode, input string req);
        int n = 0;
        int k = 0;
        logic [15:0] held;
        bit was_busy;
        while (cfg_valid && k < 200) begin
            cfg_busy = stall(mode, k);
            was_busy = cfg_busy;
            held = cfg_word;
            if (!cfg_busy) begin
                check(cfg_word == exp_word(n), req, 32'(cfg_word), 32'(exp_word(n)));
                n++;
            end
            @(negedge clk);
            if (was_busy)
                check(cfg_valid && cfg_word == held, "R8 hold", 32'(cfg_word), 32'(held));
            k++;
        end
        cfg_busy = 1'b0;
        check(n == LEN, "R7 word count", 32'(n), 32'(LEN));
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        read_reg(4'h0, v);
        check(v == 0, "R1 readback", v, 0);
        check(!cfg_valid && !status_req && cfg_word == 0, "R1 outputs",
              {cfg_word, 14'b0, cfg_valid, status_req}, 0);

        // sweep: prior arming x unlock x trigger
        for (int p = 0; p < 2; p++) begin
            for (int u = 0; u < 2; u++) begin
                for (int t = 0; t < 2; t++) begin
                    bit fire;
                    do_write(4'h0, 32'h0);
                    if (p == 1) do_write(4'h0, 32'h0001_0000);
                    read_reg(4'h0, v);
                    check(v[16] == p[0], "R2 armed readback", 32'(v[16]), 32'(p));
                    do_write(4'h0, (32'(u) << 16) | (32'(t) << 17));
                    fire = (p == 1) && (t == 1) && (u == 0);
                    check(cfg_valid == fire, fire ? "R3 fire" : "R4/R5 no fire",
                          32'(cfg_valid), 32'(fire));
                    check(!status_req, "R10 no pulse", 32'(status_req), 0);
                    read_reg(4'h0, v);
                    if (fire) begin
                        check(cfg_word == 16'hFFFF, "R3 first word", 32'(cfg_word), 32'hFFFF);
                        check(v == 32'h0004_0000, "R9 running readback", v, 32'h0004_0000);
                        drain(0, "R7 order");
                    end else begin
                        check(v == (32'(u) << 16), "R5 R6 armed after write", v, 32'(u) << 16);
                    end
                end
            end
        end

        // R8 under stall patterns
        for (int m = 0; m < 3; m++) begin
            do_write(4'h0, 32'h0001_0000);
            do_write(4'h0, 32'h0002_0000);
            check(cfg_valid, "R3 fire for stall", 32'(cfg_valid), 1);
            drain(m, "R8 order under stall");
        end

        // R9 trigger writes during run ignored
        do_write(4'h0, 32'h0001_0000);
        cfg_busy = 1'b1;
        do_write(4'h0, 32'h0002_0000);
        do_write(4'h0, 32'h0001_0000);
        read_reg(4'h0, v);
        check(v == 32'h0005_0000, "R9 rearm while running", v, 32'h0005_0000);
        do_write(4'h0, 32'h0002_0000);
        check(cfg_word == 16'hFFFF, "R9 no restart word", 32'(cfg_word), 32'hFFFF);
        cfg_busy = 1'b0;
        drain(0, "R9 single stream");
        repeat (3) @(negedge clk);
        check(!cfg_valid, "R9 no second stream", 32'(cfg_valid), 0);

        // R6 reserved-bit write without unlock disarms
        do_write(4'h0, 32'h0001_0000);
        do_write(4'h0, 32'h0000_0002);
        do_write(4'h0, 32'h0002_0000);
        check(!cfg_valid, "R6 disarmed trigger", 32'(cfg_valid), 0);

        // R12 reserved bits read 0
        do_write(4'h0, 32'hFFF9_FFFE);
        read_reg(4'h0, v);
        check(v == 32'h0001_0000, "R12 reserved readback", v, 32'h0001_0000);
        read_reg(4'h5, v);
        check(v == 0, "R12 other address readback", v, 0);

        // R11 other address has no effect
        do_write(4'h3, 32'h0002_0001);
        check(!cfg_valid && !status_req, "R11 no output", 32'({cfg_valid, status_req}), 0);
        read_reg(4'h0, v);
        check(v == 32'h0001_0000, "R11 armed kept", v, 32'h0001_0000);
        do_write(4'h0, 32'h0002_0000);
        check(cfg_valid, "R11 still armed fires", 32'(cfg_valid), 1);
        drain(0, "R7 after R11");

        // R10 status request pulse
        do_write(4'h0, 32'h0000_0001);
        check(status_req, "R10 pulse", 32'(status_req), 1);
        read_reg(4'h0, v);
        check(v[0] == 1'b0, "R10 bit0 readback", 32'(v[0]), 0);
        @(negedge clk);
        check(!status_req, "R10 one cycle", 32'(status_req), 0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule